// File: doc/BRIEF.md
# Tag-Tracked Reservation Station Scheduler

This block is a compact dynamic-scheduling core. Operations enter through a single issue port and are placed in a free reservation station of their class: arithmetic or address. At issue each source operand is resolved against a register status table. When no station is pending on the register, the value is copied from the architectural register file. When a station is pending, only that station's tag is stored. Register names are not kept in the station after issue.

Finished results leave a small fixed-latency execute stub on one common result bus as a tag/value pair. Every waiting station whose source tag matches picks the value up. Every register whose pending-writer tag matches is updated and marked current. A station whose operands are both present is ready to dispatch. When several stations are ready at once, the one issued earliest goes first. A station is freed when its own result appears on the bus.

The architectural registers can be observed through a read port that returns the current value and a pending flag.

Top module: `rs_sched`

## Requirements
- R1: After reset, every register r holds the value r, no register is pending, the result bus is idle and `issue_ready_o` is high for either class.
- R2: The `issue_op_i` encodings are: 0 gives src1+src2, 1 gives src1-src2, 2 gives src1 XOR src2, and 3 gives src1+imm. All results wrap to DATA_W bits. Code 3 is an address operation: the offset is kept as the second operand, the address field first holds the immediate and then holds the effective address.
- R3: Arithmetic stations carry tags 1..NUM_ALU and address stations carry tags NUM_ALU+1..NUM_ALU+NUM_MEM. Issue takes the lowest-numbered free station of the class. Tag 0 never appears on the bus.
- R4: `issue_ready_o` is low exactly when the class of `issue_op_i` has no free station. A full class does not block the other class.
- R5: Issuing to register d sets its pending flag in the next cycle. The flag clears only when the bus carries the tag currently recorded for d.
- R6: When an older writer to a register finishes after a younger one, the older result does not overwrite the register.
- R7: Operands wait for their producer's broadcast. After all issued work completes, the register file equals the results of in-order execution.
- R8: An operand whose producer broadcasts in the same cycle as the consumer issues takes the value from the bus and does not wait.
- R9: With the execute stub otherwise idle, a dependent operation broadcasts exactly EXE_LAT+1 cycles after its producer.
- R10: Among stations ready in the same cycle, the one issued earliest dispatches first, whatever its tag.
- R11: Every issued operation is broadcast exactly once, and its station is free in the cycle after the broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| issue_valid_i | input | 1 | Issue request |
| issue_op_i | input | 2 | Operation code (R2) |
| issue_dst_i | input | REG_W | Destination register |
| issue_src1_i | input | REG_W | First source register |
| issue_src2_i | input | REG_W | Second source register (ignored for code 3) |
| issue_imm_i | input | DATA_W | Immediate offset for code 3 |
| issue_ready_o | output | 1 | A station of the requested class is free |
| rd_addr_i | input | REG_W | Register observation address |
| rd_data_o | output | DATA_W | Register value |
| rd_busy_o | output | 1 | Register waits on a pending writer |
| cdb_valid_o | output | 1 | Result bus carries a result |
| cdb_tag_o | output | TAG_W | Producing station tag |
| cdb_value_o | output | DATA_W | Result value |

## Verification
The checker assumes that an issue is only counted when `issue_valid_i` and `issue_ready_o` are both high, and that the issue fields are stable during that cycle. The stimulus applies every field at the falling edge and holds it there until the request is accepted. Random operations use all four codes with arbitrary register aliasing, so producers, consumers and repeated writers overlap freely. Directed sequences place same-cycle bypass, full classes and out-of-tag-order readiness at the exact cycles where they matter.

// File: rtl/rs_pkg.sv
`timescale 1ns/1ps
package rs_pkg;
  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_XOR = 2'd2,
    OP_LEA = 2'd3
  } rs_op_e;

  function automatic logic op_is_mem(rs_op_e op);
    return op == OP_LEA;
  endfunction
endpackage

// File: rtl/rs_alloc.sv
`timescale 1ns/1ps
module rs_alloc #(
  parameter int N_ALU = 3,
  parameter int N     = 5
) (
  input  logic [N-1:0] busy_i,
  input  logic         is_mem_i,
  output logic         ready_o,
  output logic [N-1:0] pick_o
);
  logic [N-1:0] in_class;
  logic [N-1:0] free;

  for (genvar i = 0; i < N; i++) begin : g_cls
    if (i >= N_ALU) begin : g_mem
      assign in_class[i] = is_mem_i;
    end else begin : g_alu
      assign in_class[i] = !is_mem_i;
    end
  end

  assign free    = ~busy_i & in_class;
  assign ready_o = |free;

  // lowest free index of the class
  always_comb begin
    logic found;
    found  = 1'b0;
    pick_o = '0;
    for (int i = 0; i < N; i++) begin
      if (free[i] && !found) begin
        pick_o[i] = 1'b1;
        found     = 1'b1;
      end
    end
  end
endmodule

// File: rtl/rs_age_pick.sv
`timescale 1ns/1ps
module rs_age_pick #(
  parameter int N = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] alloc_i,
  input  logic [N-1:0] busy_i,
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  // older_q[i][j]: station j was issued before station i
  logic [N-1:0] older_q [N];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) older_q[i] <= '0;
    end else begin
      for (int k = 0; k < N; k++) begin
        if (alloc_i[k]) begin
          for (int i = 0; i < N; i++) older_q[i][k] <= 1'b0;
          older_q[k] <= busy_i;
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < N; i++) begin
      gnt_o[i] = req_i[i] && ((req_i & older_q[i]) == '0);
    end
  end
endmodule

// File: rtl/rs_exec.sv
`timescale 1ns/1ps
module rs_exec
  import rs_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3,
  parameter int LAT    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic [TAG_W-1:0]  tag_i,
  input  rs_op_e            op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] value_o
);
  logic [LAT-1:0]    vld_q;
  logic [TAG_W-1:0]  tag_q [LAT];
  logic [DATA_W-1:0] val_q [LAT];
  logic [DATA_W-1:0] res;

  always_comb begin
    unique case (op_i)
      OP_SUB:  res = a_i - b_i;
      OP_XOR:  res = a_i ^ b_i;
      default: res = a_i + b_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q <= '0;
      for (int s = 0; s < LAT; s++) begin
        tag_q[s] <= '0;
        val_q[s] <= '0;
      end
    end else begin
      vld_q[0] <= go_i;
      tag_q[0] <= tag_i;
      val_q[0] <= res;
      for (int s = 1; s < LAT; s++) begin
        vld_q[s] <= vld_q[s-1];
        tag_q[s] <= tag_q[s-1];
        val_q[s] <= val_q[s-1];
      end
    end
  end

  assign valid_o = vld_q[LAT-1];
  assign tag_o   = tag_q[LAT-1];
  assign value_o = val_q[LAT-1];
endmodule

// File: rtl/rs_sched.sv
`timescale 1ns/1ps
module rs_sched
  import rs_pkg::*;
#(
  parameter int  DATA_W   = 16,
  parameter int  NUM_REGS = 8,
  parameter int  NUM_ALU  = 3,
  parameter int  NUM_MEM  = 2,
  parameter int  EXE_LAT  = 2,
  localparam int NUM_RS   = NUM_ALU + NUM_MEM,
  localparam int TAG_W    = $clog2(NUM_RS + 1),
  localparam int IDX_W    = (NUM_RS > 1) ? $clog2(NUM_RS) : 1,
  localparam int REG_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              issue_valid_i,
  input  logic [1:0]        issue_op_i,
  input  logic [REG_W-1:0]  issue_dst_i,
  input  logic [REG_W-1:0]  issue_src1_i,
  input  logic [REG_W-1:0]  issue_src2_i,
  input  logic [DATA_W-1:0] issue_imm_i,
  output logic              issue_ready_o,
  input  logic [REG_W-1:0]  rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_busy_o,
  output logic              cdb_valid_o,
  output logic [TAG_W-1:0]  cdb_tag_o,
  output logic [DATA_W-1:0] cdb_value_o
);
  // station state
  logic [NUM_RS-1:0]             st_busy, st_sent;
  rs_op_e                        st_op [NUM_RS];
  logic [NUM_RS-1:0][TAG_W-1:0]  st_qj, st_qk;
  logic [DATA_W-1:0]             st_vj [NUM_RS];
  logic [DATA_W-1:0]             st_vk [NUM_RS];
  logic [DATA_W-1:0]             st_a  [NUM_RS];

  // register status
  logic [NUM_REGS-1:0][TAG_W-1:0] reg_qi;
  logic [DATA_W-1:0]              reg_val [NUM_REGS];

  rs_op_e            iss_op;
  logic              iss_mem, issue_fire;
  logic [NUM_RS-1:0] alloc_oh, alloc_fire_oh;
  logic [IDX_W-1:0]  alloc_idx;
  logic [TAG_W-1:0]  alloc_tag;
  logic [TAG_W-1:0]  src1_tag, src2_tag, iss_qj, iss_qk;
  logic [DATA_W-1:0] iss_vj, iss_vk;

  logic [NUM_RS-1:0] disp_req, disp_gnt, cdb_oh;
  logic              d_go;
  rs_op_e            d_op;
  logic [TAG_W-1:0]  d_tag;
  logic [DATA_W-1:0] d_a, d_b;

  assign iss_op  = rs_op_e'(issue_op_i);
  assign iss_mem = op_is_mem(iss_op);

  rs_alloc #(.N_ALU(NUM_ALU), .N(NUM_RS)) u_alloc (
    .busy_i   (st_busy),
    .is_mem_i (iss_mem),
    .ready_o  (issue_ready_o),
    .pick_o   (alloc_oh)
  );

  assign issue_fire    = issue_valid_i && issue_ready_o;
  assign alloc_fire_oh = alloc_oh & {NUM_RS{issue_fire}};

  always_comb begin
    alloc_idx = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (alloc_oh[i]) alloc_idx = IDX_W'(i);
    end
    alloc_tag = TAG_W'(alloc_idx) + TAG_W'(1);
  end

  // operand resolution, with bypass from a same-cycle broadcast
  assign src1_tag = reg_qi[issue_src1_i];
  assign src2_tag = reg_qi[issue_src2_i];

  always_comb begin
    if (src1_tag == '0) begin
      iss_qj = '0;
      iss_vj = reg_val[issue_src1_i];
    end else if (cdb_valid_o && cdb_tag_o == src1_tag) begin
      iss_qj = '0;
      iss_vj = cdb_value_o;
    end else begin
      iss_qj = src1_tag;
      iss_vj = '0;
    end

    if (iss_mem) begin
      iss_qk = '0;
      iss_vk = issue_imm_i;
    end else if (src2_tag == '0) begin
      iss_qk = '0;
      iss_vk = reg_val[issue_src2_i];
    end else if (cdb_valid_o && cdb_tag_o == src2_tag) begin
      iss_qk = '0;
      iss_vk = cdb_value_o;
    end else begin
      iss_qk = src2_tag;
      iss_vk = '0;
    end
  end

  // dispatch: oldest station with both operands present
  for (genvar i = 0; i < NUM_RS; i++) begin : g_st
    assign disp_req[i] = st_busy[i] && !st_sent[i] &&
                         (st_qj[i] == '0) && (st_qk[i] == '0);
    assign cdb_oh[i]   = cdb_valid_o && (cdb_tag_o == TAG_W'(i + 1));
  end

  rs_age_pick #(.N(NUM_RS)) u_age (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .alloc_i (alloc_fire_oh),
    .busy_i  (st_busy),
    .req_i   (disp_req),
    .gnt_o   (disp_gnt)
  );

  always_comb begin
    d_go  = |disp_gnt;
    d_op  = OP_ADD;
    d_tag = '0;
    d_a   = '0;
    d_b   = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (disp_gnt[i]) begin
        d_op  = st_op[i];
        d_tag = TAG_W'(i + 1);
        d_a   = st_vj[i];
        d_b   = op_is_mem(st_op[i]) ? st_a[i] : st_vk[i];
      end
    end
  end

  rs_exec #(.DATA_W(DATA_W), .TAG_W(TAG_W), .LAT(EXE_LAT)) u_exec (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .go_i    (d_go),
    .tag_i   (d_tag),
    .op_i    (d_op),
    .a_i     (d_a),
    .b_i     (d_b),
    .valid_o (cdb_valid_o),
    .tag_o   (cdb_tag_o),
    .value_o (cdb_value_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_busy <= '0;
      st_sent <= '0;
      st_qj   <= '0;
      st_qk   <= '0;
      for (int i = 0; i < NUM_RS; i++) begin
        st_op[i] <= OP_ADD;
        st_vj[i] <= '0;
        st_vk[i] <= '0;
        st_a[i]  <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_RS; i++) begin
        if (cdb_valid_o && st_busy[i]) begin
          if (st_qj[i] == cdb_tag_o) begin
            st_vj[i] <= cdb_value_o;
            st_qj[i] <= '0;
          end
          if (st_qk[i] == cdb_tag_o) begin
            st_vk[i] <= cdb_value_o;
            st_qk[i] <= '0;
          end
        end
        if (cdb_oh[i]) begin
          st_busy[i] <= 1'b0;
          st_sent[i] <= 1'b0;
        end
        if (disp_gnt[i]) begin
          st_sent[i] <= 1'b1;
          if (op_is_mem(st_op[i])) st_a[i] <= st_vj[i] + st_a[i];
        end
        if (alloc_fire_oh[i]) begin
          st_busy[i] <= 1'b1;
          st_sent[i] <= 1'b0;
          st_op[i]   <= iss_op;
          st_qj[i]   <= iss_qj;
          st_vj[i]   <= iss_vj;
          st_qk[i]   <= iss_qk;
          st_vk[i]   <= iss_vk;
          st_a[i]    <= issue_imm_i;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_qi <= '0;
      for (int r = 0; r < NUM_REGS; r++) reg_val[r] <= DATA_W'(r);
    end else begin
      for (int r = 0; r < NUM_REGS; r++) begin
        if (cdb_valid_o && reg_qi[r] == cdb_tag_o) begin
          reg_val[r] <= cdb_value_o;
          reg_qi[r]  <= '0;
        end
      end
      // latest writer owns the register
      if (issue_fire) reg_qi[issue_dst_i] <= alloc_tag;
    end
  end

  assign rd_data_o = reg_val[rd_addr_i];
  assign rd_busy_o = reg_qi[rd_addr_i] != '0;
endmodule

// File: rtl/rs_sched_chk.sv
`timescale 1ns/1ps
module rs_sched_chk #(
  parameter int NUM_RS   = 5,
  parameter int TAG_W    = 3,
  parameter int IDX_W    = 3,
  parameter int NUM_REGS = 8,
  parameter int REG_W    = 3
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          issue_fire_i,
  input logic [REG_W-1:0]              issue_dst_i,
  input logic [NUM_RS-1:0]             alloc_oh_i,
  input logic [IDX_W-1:0]              alloc_idx_i,
  input logic [TAG_W-1:0]              alloc_tag_i,
  input logic [TAG_W-1:0]              src1_tag_i,
  input logic                          cdb_valid_i,
  input logic [TAG_W-1:0]              cdb_tag_i,
  input logic [NUM_RS-1:0]             cdb_oh_i,
  input logic [NUM_RS-1:0]             busy_i,
  input logic [NUM_RS-1:0]             gnt_i,
  input logic [NUM_REGS-1:0][TAG_W-1:0] reg_qi_i,
  input logic [NUM_RS-1:0][TAG_W-1:0]  st_qj_i
);
  assert_tag_range_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdb_valid_i |-> (cdb_tag_i != '0) && (int'(cdb_tag_i) <= NUM_RS));

  assert_alloc_free_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_fire_i |-> ($countones(alloc_oh_i) == 1) && ((alloc_oh_i & busy_i) == '0));

  assert_dst_pending_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_fire_i |=> reg_qi_i[$past(issue_dst_i)] == $past(alloc_tag_i));

  assert_bypass_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_fire_i && cdb_valid_i && src1_tag_i == cdb_tag_i)
      |=> st_qj_i[$past(alloc_idx_i)] == '0);

  assert_one_grant_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_i));

  assert_grant_busy_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gnt_i & ~busy_i) == '0);

  assert_free_after_bcast_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cdb_valid_i |=> (busy_i & $past(cdb_oh_i)) == '0);
endmodule

bind rs_sched rs_sched_chk #(
  .NUM_RS   (NUM_RS),
  .TAG_W    (TAG_W),
  .IDX_W    (IDX_W),
  .NUM_REGS (NUM_REGS),
  .REG_W    (REG_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .issue_fire_i (issue_fire),
  .issue_dst_i  (issue_dst_i),
  .alloc_oh_i   (alloc_oh),
  .alloc_idx_i  (alloc_idx),
  .alloc_tag_i  (alloc_tag),
  .src1_tag_i   (src1_tag),
  .cdb_valid_i  (cdb_valid_o),
  .cdb_tag_i    (cdb_tag_o),
  .cdb_oh_i     (cdb_oh),
  .busy_i       (st_busy),
  .gnt_i        (disp_gnt),
  .reg_qi_i     (reg_qi),
  .st_qj_i      (st_qj)
);

// File: tb/rs_sched_test.sv
`timescale 1ns/1ps
module rs_sched_test;
  localparam int DW  = 16;
  localparam int NR  = 8;
  localparam int LAT = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          issue_valid = 1'b0;
  logic [1:0]    op = '0;
  logic [2:0]    dst = '0, src1 = '0, src2 = '0, rd_addr = '0;
  logic [DW-1:0] imm = '0;
  logic          issue_ready_o, rd_busy_o, cdb_valid_o;
  logic [DW-1:0] rd_data_o, cdb_value_o;
  logic [2:0]    cdb_tag_o;

  int n_chk = 0, n_err = 0, cyc = 0;
  int issue_count = 0, bcast_count = 0;
  int last_seen [8];
  bit done = 1'b0;
  logic [DW-1:0] ref_rf [NR];

  rs_sched uut (
    .clk_i(clk), .rst_ni(rst_n),
    .issue_valid_i(issue_valid), .issue_op_i(op), .issue_dst_i(dst),
    .issue_src1_i(src1), .issue_src2_i(src2), .issue_imm_i(imm),
    .issue_ready_o(issue_ready_o),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data_o), .rd_busy_o(rd_busy_o),
    .cdb_valid_o(cdb_valid_o), .cdb_tag_o(cdb_tag_o), .cdb_value_o(cdb_value_o)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && cdb_valid_o) begin
      bcast_count++;
      last_seen[cdb_tag_o] = cyc;
      if (cdb_tag_o == 3'd0 || cdb_tag_o > 3'd5) chk(1'b0, "R3", cdb_tag_o, 1);
    end
  end

  function automatic logic [DW-1:0] ref_calc(input logic [1:0] o, input logic [DW-1:0] a,
                                             input logic [DW-1:0] b, input logic [DW-1:0] im);
    case (o)
      2'd0: return a + b;
      2'd1: return a - b;
      2'd2: return a ^ b;
      default: return a + im;
    endcase
  endfunction

  task automatic do_issue(input logic [1:0] o, input logic [2:0] d, input logic [2:0] s1,
                          input logic [2:0] s2, input logic [DW-1:0] im);
    ref_rf[d] = ref_calc(o, ref_rf[s1], ref_rf[s2], im);
    op = o; dst = d; src1 = s1; src2 = s2; imm = im;
    issue_valid = 1'b1;
    #0.1;
    while (!issue_ready_o) begin
      @(negedge clk);
      #0.1;
    end
    @(negedge clk);
    issue_valid = 1'b0;
    issue_count++;
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [DW-1:0] v, output bit b);
    rd_addr = a;
    #0.1;
    v = rd_data_o;
    b = rd_busy_o;
  endtask

  task automatic drain();
    int n = 0;
    while (bcast_count != issue_count && n < 3000) begin
      @(negedge clk);
      n++;
    end
    repeat (3) @(negedge clk);
    chk(bcast_count == issue_count, "R11", bcast_count, issue_count);
  endtask

  task automatic wait_bcast(input logic [2:0] t);
    int n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!(cdb_valid_o && cdb_tag_o == t) && n < 1000);
    chk(cdb_valid_o && cdb_tag_o == t, "R11", cdb_tag_o, t);
  endtask

  task automatic compare_all();
    logic [DW-1:0] v;
    bit b;
    for (int r = 0; r < NR; r++) begin
      read_reg(3'(r), v, b);
      chk(v == ref_rf[r], "R7", v, ref_rf[r]);
      chk(!b, "R5", b, 0);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
  endtask

  initial begin
    #750000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL R11 watchdog expired actual=0 expected=1");
      summary();
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    bit b;
    for (int t = 0; t < 8; t++) last_seen[t] = 0;
    for (int r = 0; r < NR; r++) ref_rf[r] = DW'(r);
    void'($urandom(32'd20240611));

    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    for (int r = 0; r < NR; r++) begin
      read_reg(3'(r), v, b);
      chk(v == DW'(r), "R1", v, r);
      chk(!b, "R1", b, 0);
    end
    chk(!cdb_valid_o, "R1", cdb_valid_o, 0);
    op = 2'd0; #0.1;
    chk(issue_ready_o, "R1", issue_ready_o, 1);
    op = 2'd3; #0.1;
    chk(issue_ready_o, "R1", issue_ready_o, 1);

    // R9: producer to consumer spacing; R2 result values
    do_issue(2'd0, 3'd1, 3'd2, 3'd3, '0);
    do_issue(2'd0, 3'd4, 3'd1, 3'd1, '0);
    drain();
    chk(last_seen[2] - last_seen[1] == LAT + 1, "R9", last_seen[2] - last_seen[1], LAT + 1);
    read_reg(3'd4, v, b);
    chk(v == 16'd10, "R2", v, 10);

    // R8: consumer issued in the producer's broadcast cycle
    do_issue(2'd1, 3'd1, 3'd6, 3'd2, '0);
    wait_bcast(3'd1);
    read_reg(3'd1, v, b);
    chk(b, "R5", b, 1);
    do_issue(2'd2, 3'd5, 3'd1, 3'd7, '0);
    drain();
    read_reg(3'd5, v, b);
    chk(v == ref_rf[5], "R8", v, ref_rf[5]);

    // R4: arithmetic class full, address class still free
    do_issue(2'd3, 3'd6, 3'd6, 3'd0, 16'd5);
    do_issue(2'd3, 3'd6, 3'd6, 3'd0, 16'd7);
    do_issue(2'd0, 3'd7, 3'd6, 3'd6, '0);
    do_issue(2'd0, 3'd7, 3'd7, 3'd7, '0);
    do_issue(2'd0, 3'd7, 3'd7, 3'd7, '0);
    op = 2'd0; #0.1;
    chk(!issue_ready_o, "R4", issue_ready_o, 0);
    op = 2'd3; #0.1;
    chk(issue_ready_o, "R4", issue_ready_o, 1);
    drain();
    op = 2'd0; #0.1;
    chk(issue_ready_o, "R4", issue_ready_o, 1);
    read_reg(3'd7, v, b);
    chk(v == ref_rf[7], "R2", v, ref_rf[7]);

    // R10: younger station in lower tag becomes ready together with older one
    do_issue(2'd3, 3'd1, 3'd0, 3'd0, 16'd1);
    do_issue(2'd3, 3'd1, 3'd1, 3'd0, 16'd2);
    do_issue(2'd0, 3'd2, 3'd1, 3'd1, '0);
    do_issue(2'd0, 3'd3, 3'd3, 3'd3, '0);
    do_issue(2'd0, 3'd4, 3'd2, 3'd0, '0);
    wait_bcast(3'd2);
    do_issue(2'd1, 3'd5, 3'd2, 3'd0, '0);
    drain();
    chk(last_seen[3] < last_seen[2], "R10", last_seen[3], last_seen[2]);
    compare_all();

    // R6: younger writer finishes first and must survive
    do_issue(2'd3, 3'd6, 3'd0, 3'd0, 16'd9);
    do_issue(2'd0, 3'd1, 3'd6, 3'd6, '0);
    do_issue(2'd2, 3'd1, 3'd2, 3'd3, '0);
    read_reg(3'd1, v, b);
    chk(b, "R5", b, 1);
    drain();
    read_reg(3'd1, v, b);
    chk(v == ref_rf[1], "R6", v, ref_rf[1]);

    // R7: random traffic with heavy aliasing
    for (int k = 0; k < 400; k++) begin
      do_issue(2'($urandom % 4), 3'($urandom % NR), 3'($urandom % NR),
               3'($urandom % NR), DW'($urandom));
      if ($urandom % 8 == 0) @(negedge clk);
    end
    drain();
    compare_all();

    done = 1'b1;
    summary();
    $finish;
  end
endmodule